// File: doc/BRIEF.md
# DRAM Access Cycle Decoder

This block sits on the device side of an asynchronous DRAM pin interface. A fast internal clock samples the row strobe, the two byte-lane column strobes, the write enable, the output enable and the multiplexed address. From these samples the block classifies each access and drives the internal control of a DRAM model or of a target that emulates one. The control covers the row and column address latches, one write strobe per byte lane, one output-drive enable per byte lane and the row counter used by strobe-order refresh. The storage array and analogue timing checks are not part of this block.

The pins are treated as already synchronised to the clock. Each registered output reflects the pins sampled at one clock edge and changes at that same edge. Edges are found by comparing the pins against their values at the previous edge. The cycle type follows the OR of the two column strobes, so the earlier falling strobe starts a column cycle and the later rising strobe ends it. Write strobes and output enables still follow each lane's own strobe. A decoded cycle-type code is given out so that a checker can compare it against a reference model. The block has no streaming data path, so every pin is a plain level signal.

Top module: `dram_cyc_decoder`

## Requirements
- R1: While the row strobe is sampled high, `cyc_kind` becomes 0 (idle) at that edge and no write strobe is raised. When the row strobe and both column strobes are sampled high, both `dq_oe` bits are 0 after that edge.
- R2: When the row strobe is sampled falling with both column strobes high, `row_addr` takes `addr` and `cyc_kind` becomes 4 (row-only refresh). No output lane is enabled unless a column strobe follows.
- R3: When the row strobe is sampled falling with either column strobe low, `cyc_kind` becomes 5 (strobe-order refresh). `rfsh_row` holds its value for the whole refresh. It advances by one at the edge where the row strobe is sampled high again, and it wraps from 1023 to 0.
- R4: With the row strobe held low, the first column strobe to fall ends a time when both were high. That edge latches `col_addr` from `addr` and sets the cycle type. A lane strobe that falls later, while the other is still low, does not relatch the column.
- R5: If the write enable is low at that first column fall, `cyc_kind` becomes 2 (early write) and both `dq_oe` bits stay 0 for the rest of that column cycle.
- R6: If the write enable falls during a read while a column strobe is low, `cyc_kind` becomes 3 (delayed write). A write strobe pulses for each lane whose strobe is low, and both `dq_oe` bits turn off.
- R7: In a read (`cyc_kind` 1), `dq_oe[i]` is 1 only for a lane whose strobe was low in the read and only while the output enable is sampled low. With the output enable high, both bits are 0.
- R8: A lane enabled by a read stays enabled until that lane's strobe and the row strobe are both sampled high. Column precharge inside a page, or the row strobe rising while the lane's strobe is still low, does not turn it off.
- R9: Each `wr_stb` bit is a one-cycle pulse, raised only for lanes whose strobe is sampled low. Bit 0 is the lower lane and bit 1 the upper lane. Strobes falling together give 2'b11. In an early write, a lane whose strobe falls later gets its own pulse at its fall.
- R10: During reset and after it, all outputs are 0 until the pins change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_lo_n | input | 1 | Lower-lane column strobe, active low |
| cas_hi_n | input | 1 | Upper-lane column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| row_addr | output | ADDR_W | Latched row address |
| col_addr | output | ADDR_W | Latched column address |
| wr_stb | output | LANES | Per-lane write pulse |
| dq_oe | output | LANES | Per-lane output drive enable |
| rfsh_row | output | ADDR_W | Refresh row counter |
| cyc_kind | output | 3 | Cycle type: 0 idle, 1 read, 2 early write, 3 delayed write, 4 row-only refresh, 5 strobe-order refresh |

## Verification
A wrong cycle type shows on `cyc_kind` at the very edge that samples the deciding pin change. It also shows at once as a missing or extra `wr_stb` pulse, or as a wrong `dq_oe` pattern. A lane enable that is held or dropped wrongly shows up first during column precharge or during a refresh hidden under a read. That is one edge after the strobe changes. A counter fault may stay hidden for many refreshes, so the bench drives the counter through its full wrap and compares it on every cycle.

// File: rtl/dram_cyc_pkg.sv
package dram_cyc_pkg;
  typedef enum logic [2:0] {
    CK_IDLE      = 3'd0,
    CK_READ      = 3'd1,
    CK_WR_EARLY  = 3'd2,
    CK_WR_LATE   = 3'd3,
    CK_RFSH_ROW  = 3'd4,
    CK_RFSH_CBR  = 3'd5
  } cyc_kind_e;
endpackage

// File: rtl/strobe_sampler.sv
// Holds the previous sample of every control pin, converted to active-high.
module strobe_sampler #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic [LANES-1:0] cas_n,
  input  logic             we_n,
  input  logic             oe_n,
  output logic             ras_now,
  output logic             ras_prev,
  output logic [LANES-1:0] cas_now,
  output logic [LANES-1:0] cas_prev,
  output logic             we_now,
  output logic             we_prev,
  output logic             oe_prev
);
  assign ras_now = ~ras_n;
  assign cas_now = ~cas_n;
  assign we_now  = ~we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_prev <= 1'b0;
      cas_prev <= '0;
      we_prev  <= 1'b0;
      oe_prev  <= 1'b0;
    end else begin
      ras_prev <= ~ras_n;
      cas_prev <= ~cas_n;
      we_prev  <= ~we_n;
      oe_prev  <= ~oe_n;
    end
  end
endmodule

// File: rtl/rfsh_counter.sv
// Row counter for strobe-order refresh; wraps naturally at 2**WIDTH.
module rfsh_counter #(
  parameter int WIDTH = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bump,
  output logic [WIDTH-1:0] value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    value <= '0;
    else if (bump) value <= value + 1'b1;
  end
endmodule

// File: rtl/lane_ctl.sv
// Per-lane write pulse and output-drive hold.
module lane_ctl #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_now,
  input  logic [LANES-1:0] cas_now,
  input  logic [LANES-1:0] lane_fall,
  input  logic             start_rd,
  input  logic             start_wr,
  input  logic             ewr_mode,
  input  logic             rd_mode,
  input  logic             we_fall_rd,
  input  logic             oe_prev,
  output logic [LANES-1:0] wr_stb,
  output logic [LANES-1:0] dq_oe
);
  logic [LANES-1:0] lane_en;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic stb_d;
    assign stb_d = (start_wr & cas_now[i]) |
                   (ewr_mode & lane_fall[i]) |
                   (we_fall_rd & cas_now[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wr_stb[i]  <= 1'b0;
        lane_en[i] <= 1'b0;
      end else begin
        wr_stb[i] <= stb_d;
        // Drive ends only at the later of row and lane strobe rising.
        if (!ras_now && !cas_now[i])        lane_en[i] <= 1'b0;
        else if (start_rd)                  lane_en[i] <= cas_now[i];
        else if (start_wr || we_fall_rd)    lane_en[i] <= 1'b0;
        else if (rd_mode && lane_fall[i])   lane_en[i] <= 1'b1;
      end
    end
  end

  assign dq_oe = lane_en & {LANES{oe_prev}};
endmodule

// File: rtl/dram_cyc_decoder.sv
module dram_cyc_decoder
  import dram_cyc_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_lo_n,
  input  logic              cas_hi_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] row_addr,
  output logic [ADDR_W-1:0] col_addr,
  output logic [LANES-1:0]  wr_stb,
  output logic [LANES-1:0]  dq_oe,
  output logic [ADDR_W-1:0] rfsh_row,
  output logic [2:0]        cyc_kind
);
  localparam int CASW = LANES;

  logic             ras_now, ras_prev, we_now, we_prev, oe_prev;
  logic [CASW-1:0]  cas_now, cas_prev, cas_pins, lane_fall;
  logic             ras_held, ras_fall, ras_rise;
  logic             cas_any, cas_any_q, cas_fall, we_fall, not_cbr;
  logic             start_rd, start_wr, ewr_mode, rd_mode, we_fall_rd;
  cyc_kind_e        kind_q, kind_d;

  // Lanes other than the two named strobes (wider variants) stay idle.
  for (genvar j = 0; j < CASW; j++) begin : g_pin
    if (j == 0)      begin : g_lo assign cas_pins[j] = cas_lo_n; end
    else if (j == 1) begin : g_hi assign cas_pins[j] = cas_hi_n; end
    else             begin : g_nc assign cas_pins[j] = 1'b1;     end
  end

  strobe_sampler #(.LANES(CASW)) u_smp (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_pins),
    .we_n(we_n), .oe_n(oe_n),
    .ras_now(ras_now), .ras_prev(ras_prev),
    .cas_now(cas_now), .cas_prev(cas_prev),
    .we_now(we_now), .we_prev(we_prev), .oe_prev(oe_prev)
  );

  assign ras_held   = ras_now & ras_prev;
  assign ras_fall   = ras_now & ~ras_prev;
  assign ras_rise   = ~ras_now & ras_prev;
  assign cas_any    = |cas_now;
  assign cas_any_q  = |cas_prev;
  assign cas_fall   = cas_any & ~cas_any_q;
  assign lane_fall  = cas_now & ~cas_prev;
  assign we_fall    = we_now & ~we_prev;
  assign not_cbr    = (kind_q != CK_RFSH_CBR);
  assign start_rd   = ras_held & not_cbr & cas_fall & ~we_now;
  assign start_wr   = ras_held & not_cbr & cas_fall & we_now;
  assign ewr_mode   = ras_held & (kind_q == CK_WR_EARLY) & ~cas_fall;
  assign rd_mode    = ras_held & (kind_q == CK_READ) & ~cas_fall;
  assign we_fall_rd = rd_mode & cas_any & we_fall;

  always_comb begin
    kind_d = kind_q;
    if (!ras_now)        kind_d = CK_IDLE;
    else if (ras_fall)   kind_d = cas_any ? CK_RFSH_CBR : CK_RFSH_ROW;
    else if (start_rd)   kind_d = CK_READ;
    else if (start_wr)   kind_d = CK_WR_EARLY;
    else if (we_fall_rd) kind_d = CK_WR_LATE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q   <= CK_IDLE;
      row_addr <= '0;
      col_addr <= '0;
    end else begin
      kind_q <= kind_d;
      if (ras_fall && !cas_any)   row_addr <= addr;
      if (start_rd || start_wr)   col_addr <= addr;
    end
  end

  rfsh_counter #(.WIDTH(ADDR_W)) u_rfsh (
    .clk(clk), .rst_n(rst_n),
    .bump(ras_rise && kind_q == CK_RFSH_CBR),
    .value(rfsh_row)
  );

  lane_ctl #(.LANES(CASW)) u_lane (
    .clk(clk), .rst_n(rst_n), .ras_now(ras_now), .cas_now(cas_now),
    .lane_fall(lane_fall), .start_rd(start_rd), .start_wr(start_wr),
    .ewr_mode(ewr_mode), .rd_mode(rd_mode), .we_fall_rd(we_fall_rd),
    .oe_prev(oe_prev), .wr_stb(wr_stb), .dq_oe(dq_oe)
  );

  assign cyc_kind = kind_q;
endmodule

// File: rtl/dram_cyc_decoder_chk.sv
module dram_cyc_decoder_chk #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ras_n,
  input logic              cas_lo_n,
  input logic              cas_hi_n,
  input logic              oe_n,
  input logic [ADDR_W-1:0] addr,
  input logic [ADDR_W-1:0] row_addr,
  input logic [LANES-1:0]  wr_stb,
  input logic [LANES-1:0]  dq_oe,
  input logic [ADDR_W-1:0] rfsh_row,
  input logic [2:0]        cyc_kind
);
  p_standby_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n && cas_lo_n && cas_hi_n) |=> (dq_oe == '0));

  p_row_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && $past(ras_n) && cas_lo_n && cas_hi_n) |=> (row_addr == $past(addr)));

  p_rfsh_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_kind == 3'd5 && ras_n) |=> (rfsh_row == $past(rfsh_row) + 1'b1));

  p_early_no_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_kind == 3'd2) |-> (dq_oe == '0));

  p_late_no_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_kind == 3'd3) |-> (dq_oe == '0));

  p_drive_needs_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe != '0) |-> !$past(oe_n));

  p_stb_lo_lane_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb[0] |-> !$past(cas_lo_n));

  p_stb_hi_lane_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb[LANES-1] |-> !$past(cas_hi_n));
endmodule

bind dram_cyc_decoder dram_cyc_decoder_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_lo_n(cas_lo_n),
  .cas_hi_n(cas_hi_n), .oe_n(oe_n), .addr(addr), .row_addr(row_addr),
  .wr_stb(wr_stb), .dq_oe(dq_oe), .rfsh_row(rfsh_row), .cyc_kind(cyc_kind)
);

// File: tb/dram_cyc_decoder_bench.sv
`timescale 1ns/1ps
module dram_cyc_decoder_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ras_n = 1'b1, cas_lo_n = 1'b1, cas_hi_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [9:0] addr = '0;
  logic [9:0] row_addr, col_addr, rfsh_row;
  logic [1:0] wr_stb, dq_oe;
  logic [2:0] cyc_kind;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dram_cyc_decoder u_dram_cyc_decoder (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_lo_n(cas_lo_n),
    .cas_hi_n(cas_hi_n), .we_n(we_n), .oe_n(oe_n), .addr(addr),
    .row_addr(row_addr), .col_addr(col_addr), .wr_stb(wr_stb),
    .dq_oe(dq_oe), .rfsh_row(rfsh_row), .cyc_kind(cyc_kind)
  );

  // ---------------- behavioural reference, updated each edge ----------------
  int   m_kind = 0, m_row = 0, m_col = 0, m_cnt = 0;
  logic [1:0] m_en = '0, m_stb = '0, p_c = '0;
  bit   p_ras = 0, p_we = 0, p_oe = 0;

  always @(posedge clk) begin
    bit a_ras, a_we, any, pany;
    logic [1:0] a_c, nstb;
    if (!rst_n) begin
      m_kind = 0; m_row = 0; m_col = 0; m_cnt = 0;
      m_en = '0; m_stb = '0; p_c = '0; p_ras = 0; p_we = 0; p_oe = 0;
    end else begin
      a_ras = !ras_n; a_we = !we_n;
      a_c = {!cas_hi_n, !cas_lo_n};
      any = (a_c != 0); pany = (p_c != 0);
      nstb = '0;
      if (!a_ras) begin
        if (m_kind == 5 && p_ras) m_cnt = (m_cnt + 1) % 1024;
        m_kind = 0;
      end else if (!p_ras) begin
        if (any) m_kind = 5;
        else begin m_kind = 4; m_row = addr; end
      end else if (m_kind != 5) begin
        if (any && !pany) begin
          m_col = addr;
          if (a_we) begin m_kind = 2; nstb = a_c; m_en = '0; end
          else      begin m_kind = 1; m_en = a_c; end
        end else if (m_kind == 2) begin
          nstb = a_c & ~p_c;
        end else if (m_kind == 1) begin
          if (any && a_we && !p_we) begin m_kind = 3; nstb = a_c; m_en = '0; end
          else m_en = m_en | (a_c & ~p_c);
        end
      end
      for (int i = 0; i < 2; i++) if (!a_ras && !a_c[i]) m_en[i] = 1'b0;
      m_stb = nstb;
      p_ras = a_ras; p_c = a_c; p_we = a_we; p_oe = !oe_n;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the reference, away from the edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cyc_kind == m_kind[2:0], "R4 cyc_kind", cyc_kind, m_kind);
      check(row_addr == m_row[9:0], "R2 row_addr", row_addr, m_row);
      check(col_addr == m_col[9:0], "R4 col_addr", col_addr, m_col);
      check(rfsh_row == m_cnt[9:0], "R3 rfsh_row", rfsh_row, m_cnt);
      check(wr_stb == m_stb, "R9 wr_stb", wr_stb, m_stb);
      check(dq_oe == (m_en & {p_oe, p_oe}), "R7 dq_oe", dq_oe, m_en & {p_oe, p_oe});
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic pins(input bit r, input bit cl, input bit ch, input bit w, input bit o,
                      input logic [9:0] a);
    ras_n = r; cas_lo_n = cl; cas_hi_n = ch; we_n = w; oe_n = o; addr = a;
    tick();
  endtask

  int base;

  initial begin
    repeat (3) tick();
    // R10 reset values
    check(cyc_kind == 0 && dq_oe == 0 && wr_stb == 0 && rfsh_row == 0 &&
          row_addr == 0 && col_addr == 0, "R10 reset", cyc_kind, 0);
    rst_n = 1'b1; tick();
    check(cyc_kind == 0 && dq_oe == 0, "R10 after reset", cyc_kind, 0);

    // R2 row-only refresh
    pins(0, 1, 1, 1, 0, 10'h155);
    check(row_addr == 10'h155, "R2 row latch", row_addr, 10'h155);
    check(cyc_kind == 4 && dq_oe == 0, "R2 kind", cyc_kind, 4);
    pins(1, 1, 1, 1, 0, 10'h000);
    check(cyc_kind == 0, "R1 idle", cyc_kind, 0);

    // Read, EDO hold, second column on lower lane, output enable gate
    pins(0, 1, 1, 1, 0, 10'h0A3);
    pins(0, 0, 0, 1, 0, 10'h02C);
    check(cyc_kind == 1 && col_addr == 10'h02C, "R4 read start", cyc_kind, 1);
    check(dq_oe == 2'b11, "R7 word read", dq_oe, 2'b11);
    pins(0, 1, 1, 1, 0, 10'h02C);
    check(dq_oe == 2'b11, "R8 precharge hold", dq_oe, 2'b11);
    pins(0, 0, 1, 1, 0, 10'h02D);
    check(dq_oe == 2'b01 && col_addr == 10'h02D, "R7 lower lane", dq_oe, 2'b01);
    pins(0, 0, 1, 1, 1, 10'h02D);
    check(dq_oe == 2'b00, "R7 oe high", dq_oe, 2'b00);
    pins(1, 1, 1, 1, 0, 10'h000);
    check(dq_oe == 2'b00 && cyc_kind == 0, "R1 standby off", dq_oe, 2'b00);

    // Early write upper lane, then staggered lower lane
    pins(0, 1, 1, 1, 1, 10'h011);
    pins(0, 1, 0, 0, 1, 10'h005);
    check(cyc_kind == 2 && wr_stb == 2'b10 && dq_oe == 0, "R5 early write", wr_stb, 2'b10);
    pins(0, 1, 0, 0, 0, 10'h3FF);
    check(wr_stb == 2'b00 && dq_oe == 0, "R9 pulse width", wr_stb, 2'b00);
    pins(0, 0, 0, 0, 0, 10'h3FF);
    check(wr_stb == 2'b01 && col_addr == 10'h005, "R4 staggered lane", wr_stb, 2'b01);
    pins(1, 1, 1, 1, 1, 10'h000);

    // Delayed write from a word read
    pins(0, 1, 1, 1, 0, 10'h022);
    pins(0, 0, 0, 1, 0, 10'h033);
    check(dq_oe == 2'b11, "R7 read before write", dq_oe, 2'b11);
    pins(0, 0, 0, 0, 1, 10'h033);
    check(cyc_kind == 3 && wr_stb == 2'b11 && dq_oe == 0, "R6 delayed write", wr_stb, 2'b11);
    pins(0, 0, 0, 0, 1, 10'h033);
    check(wr_stb == 2'b00, "R9 single pulse", wr_stb, 2'b00);
    pins(1, 1, 1, 1, 1, 10'h000);

    // Refresh hidden under a lower-lane read
    pins(0, 1, 1, 1, 0, 10'h044);
    pins(0, 0, 1, 1, 0, 10'h055);
    check(dq_oe == 2'b01, "R7 lower read", dq_oe, 2'b01);
    pins(1, 0, 1, 1, 0, 10'h055);
    check(dq_oe == 2'b01 && cyc_kind == 0, "R8 later rising edge", dq_oe, 2'b01);
    base = rfsh_row;
    pins(0, 0, 1, 1, 0, 10'h055);
    check(cyc_kind == 5 && dq_oe == 2'b01, "R3 hidden refresh", cyc_kind, 5);
    pins(0, 0, 1, 1, 0, 10'h055);
    check(rfsh_row == base[9:0], "R3 counter steady", rfsh_row, base);
    pins(1, 0, 1, 1, 0, 10'h055);
    check(rfsh_row == base[9:0] + 10'd1, "R3 counter step", rfsh_row, base + 1);
    pins(1, 1, 1, 1, 0, 10'h055);
    check(dq_oe == 2'b00, "R8 both high off", dq_oe, 2'b00);

    // Counter wrap
    while (rfsh_row != 10'h3FF) begin
      pins(1, 0, 0, 1, 1, 10'h0);
      pins(0, 0, 0, 1, 1, 10'h0);
      pins(1, 0, 0, 1, 1, 10'h0);
      pins(1, 1, 1, 1, 1, 10'h0);
    end
    pins(1, 0, 0, 1, 1, 10'h0);
    pins(0, 0, 0, 1, 1, 10'h0);
    pins(1, 0, 0, 1, 1, 10'h0);
    check(rfsh_row == 10'h000, "R3 wrap", rfsh_row, 0);
    pins(1, 1, 1, 1, 1, 10'h0);

    // Read with write and output enables both high
    pins(0, 1, 1, 1, 1, 10'h066);
    pins(0, 0, 0, 1, 1, 10'h077);
    check(cyc_kind == 1 && dq_oe == 0, "R7 read disabled", dq_oe, 0);
    pins(1, 1, 1, 1, 1, 10'h0);
    tick();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule